// File: doc/BRIEF.md
# Memory-mapped I/O address decoder

This block is the glue between a processor's data port, a data memory and two small I/O devices. On every access it looks at the full 32-bit address. It steers the processor's write strobe to exactly one target: the memory, the output register of device one, or the output register of device two. It also picks which source drives the read data back to the processor.

Each device owns one 32-bit output register that the processor writes with an ordinary store. Each device also presents a 32-bit input value that the processor reads with an ordinary load. Only two word addresses at the very top of the address space belong to the devices. Every other address reaches memory.

The decode and the read selection are purely combinational from the address and the write strobe. The only state is the two device registers. They clear on reset and change only on a store to their own address.

Top module: `mmio_decoder`

## Requirements
- R1: A store (`bus_we`=1) to address 0xFFFFFFF4 loads `bus_wdata` into the device-one register on that clock edge; `dev1_out` shows the new value after the edge.
- R2: A store to address 0xFFFFFFF8 loads `bus_wdata` into the device-two register on that clock edge; `dev2_out` shows the new value after the edge.
- R3: A store to either device address leaves `mem_we` low, and at most one of the three write enables is active at any time.
- R4: A store to any non-device address drives `mem_we` high in the same cycle and leaves both device registers unchanged.
- R5: `rd_sel` is 2'b00 for memory, 2'b01 for device one and 2'b10 for device two (never 2'b11). `bus_rdata` equals `mem_rdata`, `dev1_in` or `dev2_in` respectively.
- R6: While `rst_n` is low, both device registers are zero.
- R7: A load (`bus_we`=0) has no side effects: it does not change either device register, even at a device address with arbitrary `bus_wdata`.
- R8: Decoding is exact on the full address: neighbouring words 0xFFFFFFF0 and 0xFFFFFFFC, and addresses that differ only in upper bits (such as 0x7FFFFFF4), go to memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Processor byte address |
| bus_we | input | 1 | Processor write strobe |
| bus_wdata | input | 32 | Processor store data |
| bus_rdata | output | 32 | Load data returned to the processor |
| mem_we | output | 1 | Write enable to the data memory |
| mem_rdata | input | 32 | Read data from the data memory |
| dev1_in | input | 32 | Value device one offers for loads |
| dev2_in | input | 32 | Value device two offers for loads |
| dev1_out | output | 32 | Device-one output register |
| dev2_out | output | 32 | Device-two output register |
| rd_sel | output | 2 | Read source select (00 memory, 01 device one, 10 device two) |

## Verification
The decode is exercised with stores and loads at both device addresses and at ordinary memory addresses. Each of the three sources carries a distinct data pattern, so a swapped mux leg or a mis-encoded select shows up as the wrong word. Near-miss addresses (the words on either side of the window and an address that differs only in the top bit) separate an exact compare from a partial one. Loads at device addresses with nonzero store data separate a decode that gates on the strobe from one that does not. A mid-run reset after the registers hold nonzero values shows the clear.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
    localparam int NUM_DEV = 2;

    typedef enum logic [1:0] {
        SRC_MEM  = 2'b00,
        SRC_DEV1 = 2'b01,
        SRC_DEV2 = 2'b10
    } src_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
    parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    output logic               mem_we,
    output logic [NUM_DEV-1:0] dev_we,
    output src_e               sel
);
    logic [NUM_DEV-1:0] hit;

    always_comb begin
        hit[0] = (addr == DEV1_ADDR);
        hit[1] = (addr == DEV2_ADDR);
        dev_we = hit & {NUM_DEV{we}};
        mem_we = we & ~(|hit);
        unique case (1'b1)
            hit[0]:  sel = SRC_DEV1;
            hit[1]:  sel = SRC_DEV2;
            default: sel = SRC_MEM;
        endcase
    end

    // R3: one write target at most, never memory on a device store
    always_comb begin
        if (!$isunknown({addr, we})) begin
            a_r3_single_target: assert ($countones({mem_we, dev_we}) <= 1)
                else $error("R3: more than one write enable");
            a_r3_no_mem_on_io: assert (!(we && (addr == DEV1_ADDR || addr == DEV2_ADDR)) || !mem_we)
                else $error("R3: memory written on a device store");
            a_r5_sel_legal: assert (sel != src_e'(2'b11))
                else $error("R5: illegal select");
        end
    end
endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs
    import mmio_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_DEV-1:0]              dev_we,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_DEV-1:0][DATA_W-1:0]  dev_q
);
    typedef struct packed {
        logic [NUM_DEV-1:0][DATA_W-1:0] dev;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (dev_we[i]) regs_d.dev[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dev_q = regs_q.dev;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_chk
        // R1 / R2: an enabled register captures the store data
        a_r1_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            dev_we[g] |=> dev_q[g] == $past(wdata))
            else $error("R1/R2: device %0d missed a store", g);
        // R7: a register without its enable holds
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !dev_we[g] |=> $stable(dev_q[g]))
            else $error("R7: device %0d changed without a store", g);
    end
endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
    import mmio_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_e                            sel,
    input  logic [DATA_W-1:0]               mem_rdata,
    input  logic [NUM_DEV-1:0][DATA_W-1:0]  dev_in,
    output logic [DATA_W-1:0]               rdata
);
    always_comb begin
        unique case (sel)
            SRC_DEV1: rdata = dev_in[0];
            SRC_DEV2: rdata = dev_in[1];
            default:  rdata = mem_rdata;
        endcase
    end
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
    import mmio_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
    parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev1_in,
    input  logic [DATA_W-1:0] dev2_in,
    output logic [DATA_W-1:0] dev1_out,
    output logic [DATA_W-1:0] dev2_out,
    output logic [1:0]        rd_sel
);
    logic [NUM_DEV-1:0]             dev_we;
    src_e                           sel;
    logic [NUM_DEV-1:0][DATA_W-1:0] dev_q;
    logic [NUM_DEV-1:0][DATA_W-1:0] dev_in_v;

    assign dev_in_v = {dev2_in, dev1_in};

    mmio_addr_decode #(
        .ADDR_W(ADDR_W), .DEV1_ADDR(DEV1_ADDR), .DEV2_ADDR(DEV2_ADDR)
    ) u_dec (
        .addr(bus_addr), .we(bus_we), .mem_we(mem_we), .dev_we(dev_we), .sel(sel)
    );

    mmio_dev_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .dev_we(dev_we), .wdata(bus_wdata), .dev_q(dev_q)
    );

    mmio_rd_mux #(.DATA_W(DATA_W)) u_mux (
        .sel(sel), .mem_rdata(mem_rdata), .dev_in(dev_in_v), .rdata(bus_rdata)
    );

    assign dev1_out = dev_q[0];
    assign dev2_out = dev_q[1];
    assign rd_sel   = 2'(sel);

    // R4: an ordinary store reaches memory in the same cycle
    a_r4_mem_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != DEV1_ADDR && bus_addr != DEV2_ADDR) |-> mem_we)
        else $error("R4: memory store not enabled");
endmodule

// File: tb/mmio_decoder_test.sv
module mmio_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] A_DEV1 = 32'hFFFF_FFF4;
    localparam logic [31:0] A_DEV2 = 32'hFFFF_FFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, mem_rdata = '0, dev1_in = '0, dev2_in = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata, dev1_out, dev2_out;
    logic        mem_we;
    logic [1:0]  rd_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .dev1_in(dev1_in), .dev2_in(dev2_in),
        .dev1_out(dev1_out), .dev2_out(dev2_out), .rd_sel(rd_sel)
    );

    typedef struct {
        string       tag;
        logic [31:0] rdata;
        logic [1:0]  sel;
        logic        mwe;
        logic [31:0] d1;
        logic [31:0] d2;
    } item_t;

    item_t       sb[$];
    event        ev_mon;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_d1 = '0, m_d2 = '0;
    int          seq = 0;
    bit          done = 0;

    task automatic drive(input string tag, input logic [31:0] addr,
                         input logic we, input logic [31:0] wd);
        item_t it;
        @(negedge clk);
        seq++;
        bus_addr  = addr;
        bus_we    = we;
        bus_wdata = wd;
        mem_rdata = 32'hA000_0000 | 32'(seq);
        dev1_in   = 32'hB100_0000 | 32'(seq * 3);
        dev2_in   = 32'hC200_0000 | 32'(seq * 5);
        it.tag = tag;
        if (addr == A_DEV1)      begin it.sel = 2'b01; it.rdata = dev1_in; end
        else if (addr == A_DEV2) begin it.sel = 2'b10; it.rdata = dev2_in; end
        else                     begin it.sel = 2'b00; it.rdata = mem_rdata; end
        it.mwe = we && (it.sel == 2'b00);
        it.d1  = m_d1;
        it.d2  = m_d2;
        sb.push_back(it);
        #(CLK_PERIOD/4);
        ->ev_mon;
        #1;
        if (we && addr == A_DEV1) m_d1 = wd;
        if (we && addr == A_DEV2) m_d2 = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        m_d1 = '0;
        m_d2 = '0;
        rst_n = 1'b1;
    endtask

    always begin
        item_t e;
        @(ev_mon);
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_vec++;
            if (bus_rdata !== e.rdata || rd_sel !== e.sel || mem_we !== e.mwe ||
                dev1_out !== e.d1 || dev2_out !== e.d2) begin
                n_bad++;
                $display("FAIL %s: rdata=%h sel=%b mem_we=%b d1=%h d2=%h expected rdata=%h sel=%b mem_we=%b d1=%h d2=%h",
                         e.tag, bus_rdata, rd_sel, mem_we, dev1_out, dev2_out,
                         e.rdata, e.sel, e.mwe, e.d1, e.d2);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive("R6 reset clear", 32'h0000_0100, 1'b0, 32'h0);
        drive("R4 mem store", 32'h0000_0200, 1'b1, 32'h1111_1111);
        drive("R1 dev1 store / R3 no mem_we", A_DEV1, 1'b1, 32'h0000_002A);
        drive("R5 dev1 load / R1 captured", A_DEV1, 1'b0, 32'h0);
        drive("R2 dev2 store / R3 no mem_we", A_DEV2, 1'b1, 32'hCAFE_F00D);
        drive("R5 dev2 load / R2 captured", A_DEV2, 1'b0, 32'h0);
        drive("R8 below window", 32'hFFFF_FFF0, 1'b1, 32'hDEAD_0001);
        drive("R8 above window", 32'hFFFF_FFFC, 1'b1, 32'hDEAD_0002);
        drive("R8 upper bit differs", 32'h7FFF_FFF4, 1'b1, 32'hDEAD_0003);
        drive("R7 dev1 load with data", A_DEV1, 1'b0, 32'hFFFF_FFFF);
        drive("R7 dev2 load with data", A_DEV2, 1'b0, 32'h5555_5555);
        drive("R5 mem load", 32'h1234_5678, 1'b0, 32'h0);
        for (int i = 0; i < 24; i++) begin
            case (i % 4)
                0: drive("R1 sweep", A_DEV1, 1'b1, 32'h0100_0000 + 32'(i));
                1: drive("R2 sweep", A_DEV2, 1'b1, 32'h0200_0000 + 32'(i));
                2: drive("R4 sweep", 32'(i * 64), 1'b1, 32'h0300_0000 + 32'(i));
                default: drive("R7 sweep", (i % 8 == 3) ? A_DEV1 : A_DEV2, 1'b0, 32'hFFFF_0000);
            endcase
        end
        drive("R5 pre-reset dev", A_DEV2, 1'b0, 32'h0);
        do_reset();
        drive("R6 mid-run reset clear", A_DEV1, 1'b0, 32'h0);
        drive("R3 store after reset", A_DEV2, 1'b1, 32'h0BAD_BEEF);
        drive("R2 final state", 32'h0000_0040, 1'b0, 32'h0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule